// File: doc/BRIEF.md
# Timer Block Register File

This block is the software-visible front end of an event-timer unit. It decodes a 1 KiB window of aligned 32-bit accesses. Behind that window it holds a 64-bit main counter, a global control word, an interrupt status word and one group of configuration, comparator and route registers per timer channel. The comparator arithmetic and the interrupt delivery sit in neighbouring blocks. Those blocks take the channel registers, the live counter value and the arm and disarm pulses from this block's outputs, and they report expirations back through `irq_set`.

The main counter advances by one per clock while the global enable is set. When the enable is cleared it stops and keeps its value, and counting picks up from that same value when the enable is set again. While the enable is clear, software can load either 32-bit half of the counter. A read of the low half does not latch the high half, so software must guard against tearing across a carry. Setting the enable raises a one-cycle arm pulse for each channel whose comparator is not all ones. Clearing the enable raises a one-cycle disarm pulse for every channel.

The channel count is a parameter from 3 to 24, which is the most the timer region of the window can hold.

Top module: `tmr_regfile`

## Requirements
- R1: After reset, the following values hold: global control reads 0, the main counter is 0, status is 0, every comparator reads all ones in both halves, every route register reads 0, and `arm_pulse` and `disarm_pulse` are 0.
- R2: Word address 0x000 is the capability low word, with bits [12:8] = channel count minus one and bits [7:0] = the `REV` parameter. Address 0x004 returns `TICK_FS`, the tick period in femtoseconds. Writes to both words have no effect.
- R3: Global control sits at 0x010, with bit 0 as the enable and bit 1 as legacy routing; `legacy_mode` follows bit 1. Its other bits and the word at 0x014 read 0, and writes to them are ignored.
- R4: While enabled, the counter increments by one on every clock. While disabled, it holds. The low half reads at 0x0F0 and the high half at 0x0F4.
- R5: While disabled, a write to 0x0F0 or 0x0F4 loads that half of the counter. While enabled, such writes are ignored.
- R6: A write that takes the enable from 0 to 1 produces, in the cycle after the write edge, a one-cycle `arm_pulse` on exactly those channels whose 64-bit comparator is not all ones.
- R7: A write that takes the enable from 1 to 0 produces a one-cycle `disarm_pulse` on every channel, and the counter freezes at its value after that edge.
- R8: Status sits at 0x020, with bit n for channel n. An `irq_set` bit sets its status bit. Writing 1 to a status bit clears it, and a set in the same cycle wins over the clear.
- R9: Channel n occupies 0x100 + 0x20·n. Offset +0 holds the config low word and +4 the config high word, which is read-only and returns `INT_CAP`. Offsets +8 and +C hold the comparator low and high words, and +10 and +14 hold the route low and high words.
- R10: In the config low word, only bits 1, 2, 3 and 8 (mask 0x10E) are writable. Bits 4 and 5 always read 1, and the other bits read 0. Reset value is 0x30.
- R11: The following read 0 and ignore writes: a channel index at or beyond the channel count, an access with address bits [1:0] nonzero, and any unmapped offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | 10 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_set | input | N_TMR | Per-channel expiry from the comparator logic |
| status | output | N_TMR | Interrupt status word |
| count_on | output | 1 | Global enable |
| legacy_mode | output | 1 | Legacy routing bit |
| main_count | output | 64 | Main counter value |
| tmr_cfg | output | N_TMR*32 | Config low word of each channel |
| tmr_cmp | output | N_TMR*64 | Comparator of each channel |
| tmr_route | output | N_TMR*64 | Route word of each channel |
| arm_pulse | output | N_TMR | One-cycle arm request per channel |
| disarm_pulse | output | N_TMR | One-cycle disarm request per channel |

## Verification
The hardest case to reach is the edge on which the enable changes. Three things happen together at that edge: the counter increments or does not, the selective arm mask is formed from comparators written earlier, and a counter write may land during the enabled phase and must be dropped. The stimulus first loads comparators so that only the middle channel has a value other than all ones. It then preloads the counter just below a 32-bit carry, toggles the enable and counts clocks from the write edge. Around those directed steps, the bench runs seeded random config, comparator, route, counter and status accesses, each checked against expected values computed by bench functions.

// File: rtl/tmr_pkg.sv
// Shared constants for the timer register file: word offsets (byte address
// divided by four) and the fixed bit masks of the configuration words.
package tmr_pkg;
    localparam logic [7:0]  W_CAP_LO  = 8'h00;
    localparam logic [7:0]  W_CAP_HI  = 8'h01;
    localparam logic [7:0]  W_GCFG    = 8'h04;
    localparam logic [7:0]  W_STAT    = 8'h08;
    localparam logic [7:0]  W_CNT_LO  = 8'h3C;
    localparam logic [7:0]  W_CNT_HI  = 8'h3D;
    localparam logic [2:0]  T_CFG_LO  = 3'd0;
    localparam logic [2:0]  T_CFG_HI  = 3'd1;
    localparam logic [2:0]  T_CMP_LO  = 3'd2;
    localparam logic [2:0]  T_CMP_HI  = 3'd3;
    localparam logic [2:0]  T_RT_LO   = 3'd4;
    localparam logic [2:0]  T_RT_HI   = 3'd5;
    localparam logic [31:0] GCFG_WMASK = 32'h0000_0003;
    localparam logic [31:0] TCFG_WMASK = 32'h0000_010E;
    localparam logic [31:0] TCFG_FIXED = 32'h0000_0030;
endpackage

// File: rtl/tmr_counter.sv
// Main counter. Advances by one per clock while run is high and holds
// otherwise. Half-word loads are accepted only while stopped; the caller
// is assumed to gate the load strobes with the stopped state.
module tmr_counter #(
    parameter int CW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          ld_lo,
    input  logic          ld_hi,
    input  logic [31:0]   ld_data,
    output logic [CW-1:0] count
);
    localparam int HW = CW / 2;

    // Count, or load one half while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (run) begin
            count <= count + CW'(1);
        end else if (ld_lo) begin
            count[HW-1:0] <= ld_data[HW-1:0];
        end else if (ld_hi) begin
            count[CW-1:HW] <= ld_data[HW-1:0];
        end
    end
endmodule

// File: rtl/tmr_chan_regs.sv
// Register group of one timer channel: config low word (masked write),
// fixed capability high word, 64-bit comparator, 64-bit route word, and
// the registered arm / disarm pulses formed on global enable edges.
// Assumes the select strobes are already qualified by address and alignment.
module tmr_chan_regs
    import tmr_pkg::*;
#(
    parameter logic [31:0] INT_CAP = 32'h0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sel_cfg,
    input  logic        sel_cmp_lo,
    input  logic        sel_cmp_hi,
    input  logic        sel_rt_lo,
    input  logic        sel_rt_hi,
    input  logic [31:0] wdata,
    input  logic        en_rise,
    input  logic        en_fall,
    output logic [31:0] cfg_lo,
    output logic [31:0] cfg_hi,
    output logic [63:0] cmp,
    output logic [63:0] route,
    output logic        arm,
    output logic        disarm
);
    assign cfg_hi = INT_CAP;

    // Config low word: only masked bits change, capability bits stay set.
    always_ff @(posedge clk) begin
        if (!rst_n)       cfg_lo <= TCFG_FIXED;
        else if (sel_cfg) cfg_lo <= (wdata & TCFG_WMASK) | TCFG_FIXED;
    end

    // Comparator halves, all ones after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)          cmp <= '1;
        else if (sel_cmp_lo) cmp[31:0]  <= wdata;
        else if (sel_cmp_hi) cmp[63:32] <= wdata;
    end

    // Route halves.
    always_ff @(posedge clk) begin
        if (!rst_n)         route <= '0;
        else if (sel_rt_lo) route[31:0]  <= wdata;
        else if (sel_rt_hi) route[63:32] <= wdata;
    end

    // One-cycle arm (skip unprogrammed comparator) and disarm pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm    <= 1'b0;
            disarm <= 1'b0;
        end else begin
            arm    <= en_rise && (cmp != '1);
            disarm <= en_fall;
        end
    end
endmodule

// File: rtl/tmr_regfile.sv
// Register window of the event-timer unit. Decodes aligned 32-bit accesses
// in a 1 KiB space, holds global control, status and the main counter, and
// instantiates one register group per channel. Reads are combinational from
// registered state. N_TMR must lie in 3..24 to fit the channel region.
module tmr_regfile
    import tmr_pkg::*;
#(
    parameter int          N_TMR   = 3,
    parameter logic [7:0]  REV     = 8'h01,
    parameter logic [31:0] TICK_FS = 32'd5_000_000,
    parameter logic [31:0] INT_CAP = 32'h00FF_0000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [9:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [N_TMR-1:0]     irq_set,
    output logic [N_TMR-1:0]     status,
    output logic                 count_on,
    output logic                 legacy_mode,
    output logic [63:0]          main_count,
    output logic [N_TMR*32-1:0]  tmr_cfg,
    output logic [N_TMR*64-1:0]  tmr_cmp,
    output logic [N_TMR*64-1:0]  tmr_route,
    output logic [N_TMR-1:0]     arm_pulse,
    output logic [N_TMR-1:0]     disarm_pulse
);
    localparam logic [31:0] CAP_LO = {19'd0, 5'(N_TMR - 1), REV};

    logic        aligned, in_tmr, glob_wr;
    logic [7:0]  word;
    logic [4:0]  tidx;
    logic [2:0]  toff;
    logic [1:0]  gcfg_q;
    logic        wr_gcfg, en_rise, en_fall;
    logic [31:0] ch_cfg_lo [N_TMR];
    logic [31:0] ch_cfg_hi [N_TMR];
    logic [63:0] ch_cmp    [N_TMR];
    logic [63:0] ch_rt     [N_TMR];

    // Address split into global word, channel index and channel offset.
    always_comb begin
        aligned = (bus_addr[1:0] == 2'b00);
        in_tmr  = |bus_addr[9:8];
        word    = bus_addr[9:2];
        tidx    = bus_addr[9:5] - 5'd8;
        toff    = bus_addr[4:2];
        glob_wr = bus_wr && aligned && !in_tmr;
        wr_gcfg = glob_wr && (word == W_GCFG);
        en_rise = wr_gcfg &&  bus_wdata[0] && !gcfg_q[0];
        en_fall = wr_gcfg && !bus_wdata[0] &&  gcfg_q[0];
    end

    // Global control word: enable and legacy bits.
    always_ff @(posedge clk) begin
        if (!rst_n)       gcfg_q <= 2'b00;
        else if (wr_gcfg) gcfg_q <= bus_wdata[1:0] & GCFG_WMASK[1:0];
    end

    assign count_on    = gcfg_q[0];
    assign legacy_mode = gcfg_q[1];

    // Status: set from channel logic, write-one-to-clear, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
        end else if (glob_wr && (word == W_STAT)) begin
            status <= (status & ~bus_wdata[N_TMR-1:0]) | irq_set;
        end else begin
            status <= status | irq_set;
        end
    end

    tmr_counter #(.CW(64)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (gcfg_q[0]),
        .ld_lo   (glob_wr && (word == W_CNT_LO) && !gcfg_q[0]),
        .ld_hi   (glob_wr && (word == W_CNT_HI) && !gcfg_q[0]),
        .ld_data (bus_wdata),
        .count   (main_count)
    );

    for (genvar i = 0; i < N_TMR; i++) begin : g_ch
        logic sel;
        assign sel = bus_wr && aligned && in_tmr && (tidx == 5'(i));

        tmr_chan_regs #(.INT_CAP(INT_CAP)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .sel_cfg    (sel && (toff == T_CFG_LO)),
            .sel_cmp_lo (sel && (toff == T_CMP_LO)),
            .sel_cmp_hi (sel && (toff == T_CMP_HI)),
            .sel_rt_lo  (sel && (toff == T_RT_LO)),
            .sel_rt_hi  (sel && (toff == T_RT_HI)),
            .wdata      (bus_wdata),
            .en_rise    (en_rise),
            .en_fall    (en_fall),
            .cfg_lo     (ch_cfg_lo[i]),
            .cfg_hi     (ch_cfg_hi[i]),
            .cmp        (ch_cmp[i]),
            .route      (ch_rt[i]),
            .arm        (arm_pulse[i]),
            .disarm     (disarm_pulse[i])
        );

        assign tmr_cfg[i*32 +: 32]   = ch_cfg_lo[i];
        assign tmr_cmp[i*64 +: 64]   = ch_cmp[i];
        assign tmr_route[i*64 +: 64] = ch_rt[i];
    end

    // Read multiplexer; anything unmapped or misaligned returns zero.
    always_comb begin
        bus_rdata = '0;
        if (aligned && in_tmr) begin
            for (int i = 0; i < N_TMR; i++) begin
                if (tidx == 5'(i)) begin
                    case (toff)
                        T_CFG_LO: bus_rdata = ch_cfg_lo[i];
                        T_CFG_HI: bus_rdata = ch_cfg_hi[i];
                        T_CMP_LO: bus_rdata = ch_cmp[i][31:0];
                        T_CMP_HI: bus_rdata = ch_cmp[i][63:32];
                        T_RT_LO:  bus_rdata = ch_rt[i][31:0];
                        T_RT_HI:  bus_rdata = ch_rt[i][63:32];
                        default:  bus_rdata = '0;
                    endcase
                end
            end
        end else if (aligned) begin
            case (word)
                W_CAP_LO: bus_rdata = CAP_LO;
                W_CAP_HI: bus_rdata = TICK_FS;
                W_GCFG:   bus_rdata = {30'd0, gcfg_q};
                W_STAT:   bus_rdata = 32'(status);
                W_CNT_LO: bus_rdata = main_count[31:0];
                W_CNT_HI: bus_rdata = main_count[63:32];
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/tmr_regfile_chk.sv
// Property checker for tmr_regfile, attached by bind. Observes ports only.
module tmr_regfile_chk #(
    parameter int N_TMR = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [9:0]       bus_addr,
    input logic [N_TMR-1:0] irq_set,
    input logic [N_TMR-1:0] status,
    input logic             count_on,
    input logic [63:0]      main_count,
    input logic [N_TMR-1:0] arm_pulse,
    input logic [N_TMR-1:0] disarm_pulse
);
    logic cnt_wr;
    assign cnt_wr = bus_wr && (bus_addr[9:3] == 7'h1E) && (bus_addr[1:0] == 2'b00);

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_on |=> (main_count == $past(main_count) + 64'd1));

    // R4
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_on && !cnt_wr) |=> $stable(main_count));

    // R6
    arm_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|arm_pulse) |-> $rose(count_on));

    // R7
    disarm_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|disarm_pulse) |-> ($fell(count_on) && (&disarm_pulse)));

    // R6
    arm_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|arm_pulse) |=> (arm_pulse == '0));

    // R8
    stat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_set) |=> ((status & $past(irq_set)) == $past(irq_set)));
endmodule

bind tmr_regfile tmr_regfile_chk #(.N_TMR(N_TMR)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .irq_set      (irq_set),
    .status       (status),
    .count_on     (count_on),
    .main_count   (main_count),
    .arm_pulse    (arm_pulse),
    .disarm_pulse (disarm_pulse)
);

// File: tb/tmr_regfile_test.sv
`timescale 1ns/1ps
module tmr_regfile_test;
    localparam int N = 3;
    localparam logic [31:0] CAPM = 32'h00FF_0000;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_wr = 1'b0;
    logic [9:0]     bus_addr = '0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [N-1:0]   irq_set = '0;
    logic [N-1:0]   status;
    logic           count_on, legacy_mode;
    logic [63:0]    main_count;
    logic [N*32-1:0] tmr_cfg;
    logic [N*64-1:0] tmr_cmp, tmr_route;
    logic [N-1:0]   arm_pulse, disarm_pulse;

    int checks = 0;
    int errors = 0;

    tmr_regfile #(.N_TMR(N), .INT_CAP(CAPM)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_set(irq_set),
        .status(status), .count_on(count_on), .legacy_mode(legacy_mode),
        .main_count(main_count), .tmr_cfg(tmr_cfg), .tmr_cmp(tmr_cmp),
        .tmr_route(tmr_route), .arm_pulse(arm_pulse), .disarm_pulse(disarm_pulse)
    );

    always #2.5 clk = ~clk;

    function automatic logic [31:0] exp_cfg(logic [31:0] v);
        return (v & 32'h0000_010E) | 32'h0000_0030;
    endfunction

    function automatic logic [9:0] taddr(int n, int off);
        return 10'(32'h100 + 32'h20 * n + off);
    endfunction

    task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [9:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r, v, hi;
        logic [63:0] c, s;
        int n, k;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(10'h010, r); chk("R1 gcfg", r, 0);
        chk("R1 count", main_count, 0);
        chk("R1 status", status, 0);
        chk("R1 pulses", {arm_pulse, disarm_pulse}, 0);
        for (int i = 0; i < N; i++) begin
            rd(taddr(i, 8), r);    chk("R1 cmp lo", r, 32'hFFFF_FFFF);
            rd(taddr(i, 12), r);   chk("R1 cmp hi", r, 32'hFFFF_FFFF);
            rd(taddr(i, 16), r);   chk("R1 route lo", r, 0);
            rd(taddr(i, 0), r);    chk("R10 cfg reset", r, 32'h30);
            rd(taddr(i, 4), r);    chk("R9 cfg hi", r, CAPM);
        end

        // R2 capability and write immunity
        rd(10'h000, r); chk("R2 cap lo", r, 32'h0000_0201);
        rd(10'h004, r); chk("R2 cap hi", r, 32'd5_000_000);
        wr(10'h000, 32'hDEAD_BEEF); wr(10'h004, 32'h0);
        rd(10'h000, r); chk("R2 cap lo after write", r, 32'h0000_0201);
        rd(10'h004, r); chk("R2 cap hi after write", r, 32'd5_000_000);

        // R3 global control masking and legacy output
        wr(10'h010, 32'hFFFF_FFFE);
        rd(10'h010, r); chk("R3 gcfg mask", r, 32'h2);
        chk("R3 legacy out", legacy_mode, 1);
        chk("R3 enable stays off", count_on, 0);
        wr(10'h014, 32'hFFFF_FFFF);
        rd(10'h014, r); chk("R3 gcfg hi", r, 0);
        wr(10'h010, 32'h0);
        chk("R3 legacy cleared", legacy_mode, 0);

        // R9 R10 random channel accesses
        for (int it = 0; it < 16; it++) begin
            k = int'($urandom % N);
            v = $urandom;
            wr(taddr(k, 0), v);
            rd(taddr(k, 0), r); chk("R10 cfg mask", r, exp_cfg(v));
            chk("R10 cfg port", tmr_cfg[k*32 +: 32], exp_cfg(v));
            wr(taddr(k, 4), ~v);
            rd(taddr(k, 4), r); chk("R9 cfg hi ro", r, CAPM);
            v = $urandom; wr(taddr(k, 8), v);
            rd(taddr(k, 8), r); chk("R9 cmp lo", r, v);
            v = $urandom; wr(taddr(k, 20), v);
            rd(taddr(k, 20), r); chk("R9 route hi", r, v);
            chk("R9 route port", tmr_route[k*64+32 +: 32], v);
        end

        // R5 random counter loads while stopped
        for (int it = 0; it < 8; it++) begin
            v = $urandom; hi = $urandom;
            wr(10'h0F0, v); wr(10'h0F4, hi);
            chk("R5 load", main_count, {hi, v});
            rd(10'h0F4, r); chk("R5 read hi", r, hi);
            rd(10'h0F0, r); chk("R4 held lo", r, v);
        end

        // R11 out-of-range, misaligned and unmapped
        wr(taddr(0, 0), 32'h0);
        wr(taddr(3, 0), 32'hFFFF_FFFF);
        wr(taddr(3, 8), 32'h1);
        rd(taddr(3, 0), r); chk("R11 oor read", r, 0);
        rd(taddr(0, 0), r); chk("R11 oor write ignored", r, 32'h30);
        wr(10'h101, 32'h4);
        rd(taddr(0, 0), r); chk("R11 misaligned write", r, 32'h30);
        rd(10'h106, r); chk("R11 misaligned read", r, 0);
        rd(taddr(0, 24), r); chk("R11 unmapped offset", r, 0);
        rd(10'h0C0, r); chk("R11 unmapped global", r, 0);
        wr(10'h013, 32'h1);
        chk("R11 misaligned gcfg", count_on, 0);

        // Comparator setup: only channel 1 programmed
        for (int i = 0; i < N; i++) begin
            wr(taddr(i, 8), 32'hFFFF_FFFF); wr(taddr(i, 12), 32'hFFFF_FFFF);
        end
        wr(taddr(1, 8), 32'h0000_1234);

        // R6 enable arms selectively; counter resumes across a carry
        s = 64'h0000_0005_FFFF_FFF0;
        wr(10'h0F0, s[31:0]); wr(10'h0F4, s[63:32]);
        wr(10'h010, 32'h1);
        chk("R6 arm mask", arm_pulse, 3'b010);
        chk("R6 no disarm", disarm_pulse, 0);
        chk("R4 resume value", main_count, s);
        @(negedge clk);
        chk("R6 arm one cycle", arm_pulse, 0);
        n = 20 + int'($urandom % 40);
        repeat (n) @(negedge clk);
        chk("R4 run count carry", main_count, s + 64'(n + 1));
        rd(10'h0F4, r); chk("R4 read hi live", r, 32'h6);

        // R5 write while running ignored
        c = main_count;
        wr(10'h0F0, 32'h0);
        chk("R5 write ignored", main_count, c + 64'd2);

        // R7 disable disarms all and freezes
        c = main_count;
        wr(10'h010, 32'h0);
        chk("R7 disarm all", disarm_pulse, 3'b111);
        chk("R7 no arm", arm_pulse, 0);
        chk("R7 frozen value", main_count, c + 64'd2);
        c = main_count;
        repeat (5) @(negedge clk);
        chk("R7 disarm one cycle", disarm_pulse, 0);
        chk("R4 hold", main_count, c);
        rd(10'h0F0, r); chk("R4 read held lo", r, c[31:0]);

        // R6 all comparators unprogrammed: no arm
        wr(taddr(1, 8), 32'hFFFF_FFFF);
        wr(10'h010, 32'h1);
        chk("R6 no arm all ones", arm_pulse, 0);
        wr(10'h010, 32'h0);

        // R8 status set, clear, collision
        @(negedge clk); irq_set = 3'b101;
        @(negedge clk); irq_set = 3'b000;
        chk("R8 set", status, 3'b101);
        wr(10'h020, 32'h4);
        rd(10'h020, r); chk("R8 w1c", r, 32'h1);
        @(negedge clk);
        bus_addr = 10'h020; bus_wdata = 32'h1; bus_wr = 1'b1; irq_set = 3'b001;
        @(negedge clk);
        bus_wr = 1'b0; irq_set = 3'b000;
        chk("R8 set wins", status, 3'b001);
        for (int it = 0; it < 8; it++) begin
            logic [N-1:0] st, m;
            st = N'($urandom); m = N'($urandom);
            wr(10'h020, 32'h7);
            @(negedge clk); irq_set = st;
            @(negedge clk); irq_set = '0;
            wr(10'h020, 32'(m));
            chk("R8 random w1c", status, st & ~m);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule